// File: doc/BRIEF.md
# Multipath Complex Channel Filter

This block imposes a multipath radio channel on a stream of complex baseband samples. Every accepted sample is pushed into a history line. Each propagation path picks one entry of that history at its own programmable delay. It multiplies that entry by a complex weight that may change with every sample, and the weighted copies of all paths are added into one complex output sample. A path can be switched off, and it then adds nothing to the output.

The weights, delays and path enables travel with the sample: they are taken in the same cycle as the sample they apply to. The upstream coefficient source therefore supplies a fresh set of weights with each sample. Both stream edges use a valid/ready handshake. The whole pipeline advances only when its output register is empty or is being drained, so `in_ready` follows `out_ready` in the same cycle. A stalled output holds its data, and no sample is dropped or duplicated. Weights are signed fractions with 15 fraction bits, so 32767 is just below unity gain.

Top module: `mpath_chan_filter`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `in_ready` is 1 until a sample has been accepted. The history line is cleared, so entries never written read as 0.
- R2: For each accepted sample n, the output is sum over enabled paths i of w_i(n)·x(n−d_i(n)), computed as a full complex product (re = wr·xr − wi·xi, im = wr·xi + wi·xr), accumulated at full precision.
- R3: With `out_ready` held at 1, the result of a sample accepted at a rising edge appears on `out_valid` exactly 3 clock cycles later. Output samples leave in acceptance order, one per accepted input, and there are no others.
- R4: A path whose bit in `path_en` is 0 contributes nothing, whatever its weight and delay. With all bits 0 the output is 0.
- R5: Path i's delay field, `path_dly` bits [4i+3:4i], selects the sample accepted that many samples earlier. 0 selects the current sample, and the range is 0 to 15.
- R6: The accumulated sum is scaled by 2^-15 with rounding to nearest, with ties rounded toward positive infinity (+0.5 rounds to 1, −0.5 rounds to 0).
- R7: A scaled result outside the signed 16-bit range is clamped to 32767 or −32768.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_re`/`out_im` hold steady and `in_ready` is 0. In all other cycles `in_ready` is 1.
- R9: Cycles without `in_valid` do not move the history line, so delays count accepted samples and not clock cycles.
- R10: Weights, delays and enables are sampled in the acceptance cycle of each sample, so each sample may use a different set. Path i's weight is `coef_re`/`coef_im` bits [16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample taken when high together with in_valid |
| in_re | input | 16 | Input sample, real part, signed |
| in_im | input | 16 | Input sample, imaginary part, signed |
| coef_re | input | 192 | Per-path weight real parts, signed Q1.15, path i at [16i+15:16i] |
| coef_im | input | 192 | Per-path weight imaginary parts, signed Q1.15 |
| path_dly | input | 48 | Per-path delay in samples, path i at [4i+3:4i] |
| path_en | input | 12 | Per-path enable, bit i for path i |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes output when high with out_valid |
| out_re | output | 16 | Output sample, real part, signed |
| out_im | output | 16 | Output sample, imaginary part, signed |

## Verification
The assertions take for granted that reset is asserted from the first clock edge. They also assume the downstream side follows the handshake, so a held output is judged only while `out_ready` stays low. The latency and masked-path properties count only handshakes seen at the ports, which relies on `in_valid` being sampled only when `in_ready` is high. The stimulus drives every input just after a falling edge and keeps inputs unchanged until the next one. It mixes continuous streams, input gaps and random output stalls. It includes directed impulses at chosen delays, rounding ties, and full-scale sums that overflow.

// File: rtl/chf_pkg.sv
package chf_pkg;
  localparam int CHF_NPATH = 12;  // number of propagation paths
  localparam int CHF_DEPTH = 16;  // history entries incl. current sample
  localparam int CHF_SW    = 16;  // sample width
  localparam int CHF_CW    = 16;  // weight width
  localparam int CHF_FRAC  = 15;  // weight fraction bits
endpackage

// File: rtl/chf_delay_line.sv
// History of accepted samples plus per-path tap selection (stage 1).
module chf_delay_line #(
  parameter int NPATH = 12,
  parameter int DEPTH = 16,
  parameter int SW    = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic                              push,
  input  logic signed [SW-1:0]              smp_re,
  input  logic signed [SW-1:0]              smp_im,
  input  logic [NPATH*$clog2(DEPTH)-1:0]    dly,
  input  logic [NPATH-1:0]                  en,
  output logic signed [SW-1:0]              tap_re [NPATH],
  output logic signed [SW-1:0]              tap_im [NPATH]
);
  localparam int DLW  = $clog2(DEPTH);
  localparam int HIST = DEPTH - 1;

  // hist[0] is the sample accepted just before the current one
  logic signed [SW-1:0] h_re [HIST];
  logic signed [SW-1:0] h_im [HIST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST; k++) begin
        h_re[k] <= '0;
        h_im[k] <= '0;
      end
    end else if (push) begin
      h_re[0] <= smp_re;
      h_im[0] <= smp_im;
      for (int k = 1; k < HIST; k++) begin
        h_re[k] <= h_re[k-1];
        h_im[k] <= h_im[k-1];
      end
    end
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [DLW-1:0]       d;
    logic signed [SW-1:0] sel_re, sel_im;
    assign d = dly[p*DLW +: DLW];

    always_comb begin
      if (d == '0) begin
        sel_re = smp_re;
        sel_im = smp_im;
      end else begin
        sel_re = h_re[DLW'(d - 1'b1)];
        sel_im = h_im[DLW'(d - 1'b1)];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_re[p] <= '0;
        tap_im[p] <= '0;
      end else if (adv) begin
        tap_re[p] <= en[p] ? sel_re : '0;
        tap_im[p] <= en[p] ? sel_im : '0;
      end
    end
  end
endmodule

// File: rtl/chf_cmul.sv
// One full complex product per path, registered (stage 2).
module chf_cmul #(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic signed [SW-1:0]     a_re,
  input  logic signed [SW-1:0]     a_im,
  input  logic signed [CW-1:0]     w_re,
  input  logic signed [CW-1:0]     w_im,
  output logic signed [SW+CW:0]    p_re,
  output logic signed [SW+CW:0]    p_im
);
  localparam int MW = SW + CW;

  logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
  assign m_rr = a_re * w_re;
  assign m_ii = a_im * w_im;
  assign m_ri = a_im * w_re;
  assign m_ir = a_re * w_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_re <= '0;
      p_im <= '0;
    end else if (adv) begin
      p_re <= $signed({m_rr[MW-1], m_rr}) - $signed({m_ii[MW-1], m_ii});
      p_im <= $signed({m_ri[MW-1], m_ri}) + $signed({m_ir[MW-1], m_ir});
    end
  end
endmodule

// File: rtl/chf_accum.sv
// Full-precision sum of all path products, round and clamp (stage 3).
module chf_accum #(
  parameter int NPATH = 12,
  parameter int PW    = 33,
  parameter int OW    = 16,
  parameter int FRAC  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic signed [PW-1:0] terms [NPATH],
  output logic signed [OW-1:0] q
);
  localparam int AW = PW + $clog2(NPATH) + 1;
  localparam logic signed [AW-1:0] OMAX = (AW'(1) <<< (OW-1)) - AW'(1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC-1);

  logic signed [AW-1:0] acc, rnd, shf;
  logic signed [OW-1:0] res;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPATH; i++) acc = acc + AW'(terms[i]);
    rnd = acc + HALF;
    shf = rnd >>> FRAC;
    if (shf > OMAX)      res = OMAX[OW-1:0];
    else if (shf < OMIN) res = OMIN[OW-1:0];
    else                 res = shf[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (adv) q <= res;
  end
endmodule

// File: rtl/mpath_chan_filter.sv
module mpath_chan_filter
  import chf_pkg::*;
#(
  parameter int NPATH = CHF_NPATH,
  parameter int DEPTH = CHF_DEPTH,
  parameter int SW    = CHF_SW,
  parameter int CW    = CHF_CW,
  parameter int FRAC  = CHF_FRAC
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic signed [SW-1:0]            in_re,
  input  logic signed [SW-1:0]            in_im,
  input  logic [NPATH*CW-1:0]             coef_re,
  input  logic [NPATH*CW-1:0]             coef_im,
  input  logic [NPATH*$clog2(DEPTH)-1:0]  path_dly,
  input  logic [NPATH-1:0]                path_en,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic signed [SW-1:0]            out_re,
  output logic signed [SW-1:0]            out_im
);
  localparam int PW = SW + CW + 1;

  logic adv, push;
  logic v1, v2, v3;

  // one stall domain: every stage moves when the output slot frees
  assign adv       = !v3 || out_ready;
  assign push      = in_valid && adv;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= push;
      v2 <= v1;
      v3 <= v2;
    end
  end

  logic signed [SW-1:0] tap_re [NPATH];
  logic signed [SW-1:0] tap_im [NPATH];

  chf_delay_line #(.NPATH(NPATH), .DEPTH(DEPTH), .SW(SW)) u_line (
    .clk(clk), .rst_n(rst_n), .adv(adv), .push(push),
    .smp_re(in_re), .smp_im(in_im),
    .dly(path_dly), .en(path_en),
    .tap_re(tap_re), .tap_im(tap_im)
  );

  logic signed [PW-1:0] prod_re [NPATH];
  logic signed [PW-1:0] prod_im [NPATH];

  for (genvar p = 0; p < NPATH; p++) begin : g_w
    logic signed [CW-1:0] w_re_q, w_im_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_re_q <= '0;
        w_im_q <= '0;
      end else if (adv) begin
        w_re_q <= coef_re[p*CW +: CW];
        w_im_q <= coef_im[p*CW +: CW];
      end
    end

    chf_cmul #(.SW(SW), .CW(CW)) u_mul (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .a_re(tap_re[p]), .a_im(tap_im[p]),
      .w_re(w_re_q), .w_im(w_im_q),
      .p_re(prod_re[p]), .p_im(prod_im[p])
    );
  end

  chf_accum #(.NPATH(NPATH), .PW(PW), .OW(SW), .FRAC(FRAC)) u_sum_re (
    .clk(clk), .rst_n(rst_n), .adv(adv), .terms(prod_re), .q(out_re)
  );

  chf_accum #(.NPATH(NPATH), .PW(PW), .OW(SW), .FRAC(FRAC)) u_sum_im (
    .clk(clk), .rst_n(rst_n), .adv(adv), .terms(prod_im), .q(out_im)
  );
endmodule

// File: rtl/chf_checker.sv
module chf_checker #(
  parameter int NPATH = 12,
  parameter int OW    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NPATH-1:0]     path_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im
);
  logic       go, took;
  logic [2:0] took_sh, zero_sh;

  assign go   = !out_valid || out_ready;
  assign took = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      took_sh <= '0;
      zero_sh <= '0;
    end else if (go) begin
      took_sh <= {took_sh[1:0], took};
      zero_sh <= {zero_sh[1:0], took && (path_en == '0)};
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == took_sh[2]); // R3
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && zero_sh[2]) |-> (out_re == '0 && out_im == '0)); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R8
  AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

bind mpath_chan_filter chf_checker #(.NPATH(NPATH), .OW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .path_en(path_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_mpath_chan_filter.sv
module tb_mpath_chan_filter;
  localparam int NP = 12, DP = 16, SW = 16, CW = 16, DLW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic signed [SW-1:0] in_re, in_im, out_re, out_im;
  logic [NP*CW-1:0] coef_re, coef_im;
  logic [NP*DLW-1:0] path_dly;
  logic [NP-1:0] path_en;

  mpath_chan_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .coef_re(coef_re), .coef_im(coef_im),
    .path_dly(path_dly), .path_en(path_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
  );

  int c_re[NP], c_im[NP], dl[NP];
  bit en[NP];
  int h_re[DP], h_im[DP];
  int q_re[$], q_im[$], q_cyc[$];
  bit q_lat[$];
  string q_tag[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit lat_mode = 1'b1;
  bit blk = 1'b0;
  logic signed [SW-1:0] blk_re, blk_im;
  bit done = 1'b0;

  task automatic check(string t, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  function automatic int rsat(longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic model_accept(int xr, int xi);
    longint sr = 0, si = 0;
    for (int k = DP - 1; k > 0; k--) begin
      h_re[k] = h_re[k-1];
      h_im[k] = h_im[k-1];
    end
    h_re[0] = xr;
    h_im[0] = xi;
    for (int i = 0; i < NP; i++) begin
      if (en[i]) begin
        sr += longint'(c_re[i]) * h_re[dl[i]] - longint'(c_im[i]) * h_im[dl[i]];
        si += longint'(c_re[i]) * h_im[dl[i]] + longint'(c_im[i]) * h_re[dl[i]];
      end
    end
    q_re.push_back(rsat(sr));
    q_im.push_back(rsat(si));
    q_cyc.push_back(cyc);
    q_lat.push_back(lat_mode);
    q_tag.push_back(tag);
  endtask

  task automatic step(bit iv, int xr, int xi, bit ordy);
    int er, ei, ec;
    bit el;
    string et;
    @(negedge clk);
    in_valid  = iv;
    in_re     = xr[SW-1:0];
    in_im     = xi[SW-1:0];
    out_ready = ordy;
    for (int i = 0; i < NP; i++) begin
      coef_re[i*CW +: CW]    = c_re[i][CW-1:0];
      coef_im[i*CW +: CW]    = c_im[i][CW-1:0];
      path_dly[i*DLW +: DLW] = dl[i][DLW-1:0];
      path_en[i]             = en[i];
    end
    #1;
    cyc++;
    if (blk) begin // R8: held output and no input taken while blocked
      check("R8", int'(out_re), int'(blk_re), "held out_re");
      check("R8", int'(out_im), int'(blk_im), "held out_im");
      check("R8", int'(out_valid), 1, "held out_valid");
    end
    if (out_valid && !out_ready) check("R8", int'(in_ready), 0, "in_ready while blocked");
    else check("R8", int'(in_ready), 1, "in_ready while free");
    if (in_valid && in_ready) model_accept(xr, xi);
    if (out_valid && out_ready) begin
      if (q_re.size() == 0) begin
        check("R3", 1, 0, "output with no pending sample");
      end else begin
        er = q_re.pop_front(); ei = q_im.pop_front();
        ec = q_cyc.pop_front(); el = q_lat.pop_front(); et = q_tag.pop_front();
        check(et, int'(out_re), er, "out_re");
        check(et, int'(out_im), ei, "out_im");
        if (el) check("R3", cyc - ec, 3, "latency in cycles");
      end
    end
    blk    = out_valid && !out_ready;
    blk_re = out_re;
    blk_im = out_im;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) step(1'b0, 0, 0, 1'b1);
    check("R3", q_re.size(), 0, "pending samples after drain");
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic all_off();
    for (int i = 0; i < NP; i++) begin
      en[i] = 1'b0; c_re[i] = 0; c_im[i] = 0; dl[i] = 0;
    end
  endtask

  initial begin
    void'($urandom(7));
    for (int k = 0; k < DP; k++) begin h_re[k] = 0; h_im[k] = 0; end
    all_off();
    rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0; out_ready = 1'b1;
    coef_re = '0; coef_im = '0; path_dly = '0; path_en = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", int'(out_valid), 0, "out_valid in reset");
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", int'(out_valid), 0, "out_valid idle after reset");
      check("R1", int'(in_ready), 1, "in_ready idle after reset");
    end

    // R1: unwritten history reads as zero (delay 15 on first samples)
    tag = "R1";
    en[0] = 1'b1; c_re[0] = 32767; dl[0] = 15;
    for (int k = 0; k < 4; k++) step(1'b1, 20000, -9000, 1'b1);
    drain();

    // R5: impulse through one path at several delays
    tag = "R5";
    all_off(); en[0] = 1'b1; c_re[0] = 32767; c_im[0] = -12000;
    foreach (dl[j]) dl[j] = 0;
    for (int d = 0; d < DP; d += 5) begin
      dl[0] = d;
      step(1'b1, 12000, 3000, 1'b1);
      for (int k = 0; k < DP; k++) step(1'b1, 0, 0, 1'b1);
    end
    drain();

    // R4: disabled paths contribute nothing
    tag = "R4";
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < NP; i++) begin
        c_re[i] = rnd16(); c_im[i] = rnd16(); dl[i] = $urandom_range(15);
        en[i] = (k >= 15) && (i % 3 == 0);
      end
      step(1'b1, rnd16(), rnd16(), 1'b1);
    end
    drain();

    // R2: all paths, continuous stream, full complex products
    tag = "R2";
    for (int i = 0; i < NP; i++) begin
      en[i] = 1'b1; dl[i] = $urandom_range(15);
    end
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < NP; i++) begin
        c_re[i] = rnd16() / 8; c_im[i] = rnd16() / 8;
      end
      step(1'b1, rnd16(), rnd16(), 1'b1);
    end
    drain();

    // R9: gaps in the input must not age the history
    tag = "R9";
    for (int k = 0; k < 200; k++) begin
      step($urandom_range(2) == 0, rnd16(), rnd16(), 1'b1);
    end
    drain();

    // R10: delays and enables change with every sample
    tag = "R10";
    for (int k = 0; k < 150; k++) begin
      for (int i = 0; i < NP; i++) begin
        dl[i] = $urandom_range(15); en[i] = $urandom_range(1);
        c_re[i] = rnd16() / 6; c_im[i] = rnd16() / 6;
      end
      step(1'b1, rnd16(), rnd16(), 1'b1);
    end
    drain();

    // R6: rounding ties with a weight of one LSB
    tag = "R6";
    all_off(); en[0] = 1'b1; c_re[0] = 1;
    step(1'b1, 16384, -16384, 1'b1);
    step(1'b1, -16384, 16383, 1'b1);
    step(1'b1, 16385, -16385, 1'b1);
    step(1'b1, 32767, -32768, 1'b1);
    drain();

    // R7: full-scale sums clamp
    tag = "R7";
    for (int i = 0; i < NP; i++) begin
      en[i] = 1'b1; dl[i] = 0; c_re[i] = 32767; c_im[i] = 0;
    end
    step(1'b1, 32767, -32768, 1'b1);
    step(1'b1, -32768, 32767, 1'b1);
    for (int i = 0; i < NP; i++) begin c_re[i] = -32768; c_im[i] = -32768; end
    step(1'b1, -32768, -32768, 1'b1);
    step(1'b1, 100, -100, 1'b1);
    drain();

    // R8: random back-pressure
    tag = "R8";
    lat_mode = 1'b0;
    for (int i = 0; i < NP; i++) begin
      en[i] = 1'b1; dl[i] = $urandom_range(15);
    end
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < NP; i++) begin
        c_re[i] = rnd16() / 8; c_im[i] = rnd16() / 8;
      end
      step($urandom_range(9) < 7, rnd16(), rnd16(), $urandom_range(1));
    end
    lat_mode = 1'b1;
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule